// File: doc/BRIEF.md
# Lattice Wave Digital Hilbert Transformer

This block turns a stream of real two's-complement samples into a complex (real, imaginary) pair that approximates a Hilbert transformer. The target response is +j for negative frequencies and −j for positive ones. Two first-order allpass branches in z² form a half-band prototype, with one branch delayed by one sample. The prototype is moved onto the complex plane by substituting −jz for z. That substitution turns every two-sample delay inside a branch into a negated two-sample delay. It also turns the lone one-sample delay into a rotated term. The result is that the imaginary output comes from branch A and the real output comes from the delayed, negated branch B. The halving factor of the prototype is an arithmetic right shift by one at each output.

Each branch is a one-multiplier wave digital adaptor. Its coefficient is a fixed canonic signed digit mask pair, realised only with shifted copies of the operand. A carry-save tree sums these copies, and one vector-merge adder per result converts back to binary. A single adaptor is shared by both branches under a four-state sequencer:

- **ST_IDLE** waits for a strobe. IDLE→BRA is taken on `in_valid`, and the sample is captured on that edge.
- **ST_BRA** runs the adaptor for branch A. BRA→BRB is taken unconditionally.
- **ST_BRB** runs the adaptor for branch B and loads both outputs. BRB→EMIT is taken unconditionally.
- **ST_EMIT** flags the result. EMIT→IDLE is taken unconditionally.

A new sample may therefore be offered at most every fourth cycle.

Top module: `lwdf_hilbert`

## Requirements
- R1: After reset `out_valid`, `out_re` and `out_im` are 0 and all delay registers hold 0, so the first sample sees a filter at rest.
- R2: A strobe accepted in ST_IDLE on clock edge t makes `out_valid` 1 for exactly the one cycle following edge t+2; `out_valid` is 0 in every other cycle.
- R3: `in_valid` in ST_BRA, ST_BRB or ST_EMIT is ignored: no capture, no state advance, and no effect on any later result.
- R4: Let x be the sample sign-extended to N=IN_W+GUARD bits and let p be branch A's register from two accepted samples earlier. The branch computes d=x+p, t=αA·d, y=t−p and a new register value t+x. The imaginary output is y arithmetic-shifted right by one.
- R5: Branch B follows the same recursion as branch A, using its own registers and αB. The real output is (−yB) arithmetic-shifted right by one, where yB is branch B's output for the previously accepted sample (0 for the first sample).
- R6: A coefficient multiply is the wrapped sum over mask bits k (k=0 is the most significant fractional digit, weight 2^-(k+1)) of +(d>>>(k+1)) where the positive mask bit is set, or −(d>>>(k+1)) where the negative mask bit is set. The defaults are αA = +2^-1 +2^-3 −2^-5 and αB = +2^-3 +2^-6.
- R7: `out_re` and `out_im` change only on the edge that enters ST_EMIT and hold their values otherwise.
- R8: All arithmetic wraps modulo 2^N with no saturation, including full-scale positive and negative inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, honoured only in ST_IDLE |
| in_sample | input | IN_W | Real input sample, two's complement |
| out_valid | output | 1 | One-cycle flag marking a new output pair |
| out_re | output | IN_W+GUARD | Real (in-phase) output |
| out_im | output | IN_W+GUARD | Imaginary (quadrature) output |

## Verification
The hardest condition to reach is a strobe that arrives while the shared adaptor is busy. A design that wrongly accepted it would corrupt the branch registers without any immediate sign at the outputs. The stimulus holds `in_valid` high with random junk on `in_sample` through ST_BRA, ST_BRB and ST_EMIT for a subset of samples. The harm from a wrong capture only shows up in later outputs of the recursive state, so every following output is compared against a reference model that never saw the junk. Long random runs with full-scale values drive the registers into wraparound, which exercises R8.

// File: rtl/lwdf_pkg.sv
package lwdf_pkg;

    // Sequencer states of the shared adaptor
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BRA  = 2'd1,
        ST_BRB  = 2'd2,
        ST_EMIT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/lwdf_csd_mul.sv
// Signed-digit constant multiply: shifted operand copies summed in carry-save form.
module lwdf_csd_mul #(
    parameter int N = 14,
    parameter int F = 8
) (
    input  logic [N-1:0] opnd,
    input  logic [F-1:0] pos_mask,
    input  logic [F-1:0] neg_mask,
    output logic [N-1:0] cs_sum,
    output logic [N-1:0] cs_carry
);

    logic [N-1:0] shifted [F];
    logic [N-1:0] term    [F];

    genvar k;
    for (k = 0; k < F; k++) begin : g_digit
        assign shifted[k] = $signed(opnd) >>> (k + 1);
        // negative digits enter as one's complement; the +1 is pre-loaded below
        assign term[k] = pos_mask[k] ? shifted[k]
                       : (neg_mask[k] ? ~shifted[k] : '0);
    end

    always_comb begin
        logic [N-1:0] s, c, ns, nc;
        s = '0;
        for (int i = 0; i < F; i++) begin
            if (neg_mask[i] && !pos_mask[i]) begin
                s = s + N'(1);
            end
        end
        c = '0;
        for (int i = 0; i < F; i++) begin
            ns = s ^ c ^ term[i];
            nc = ((s & c) | (s & term[i]) | (c & term[i])) << 1;
            s  = ns;
            c  = nc;
        end
        cs_sum   = s;
        cs_carry = c;
    end

endmodule

// File: rtl/lwdf_csa_add3.sv
// Three-operand add: one 3:2 compressor row then a single vector-merge adder.
module lwdf_csa_add3 #(
    parameter int N = 14
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] c,
    input  logic         cin,
    output logic [N-1:0] sum
);

    logic [N-1:0] part_s;
    logic [N-1:0] part_c;

    assign part_s = a ^ b ^ c;
    assign part_c = ((a & b) | (a & c) | (b & c)) << 1;
    assign sum    = part_s + part_c + {{(N-1){1'b0}}, cin};

endmodule

// File: rtl/lwdf_adaptor.sv
// One-multiplier first-order allpass adaptor working on the negated z^-2 delay.
module lwdf_adaptor #(
    parameter int N = 14,
    parameter int F = 8
) (
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] r_old,
    input  logic [F-1:0] pos_mask,
    input  logic [F-1:0] neg_mask,
    output logic [N-1:0] y_out,
    output logic [N-1:0] r_new
);

    logic [N-1:0] diff;
    logic [N-1:0] m_sum;
    logic [N-1:0] m_carry;

    // the delayed wave is -r_old, so x - (-r_old) = x + r_old
    assign diff = x_in + r_old;

    lwdf_csd_mul #(.N(N), .F(F)) u_mul (
        .opnd     (diff),
        .pos_mask (pos_mask),
        .neg_mask (neg_mask),
        .cs_sum   (m_sum),
        .cs_carry (m_carry)
    );

    // y = t - r_old
    lwdf_csa_add3 #(.N(N)) u_add_y (
        .a   (m_sum),
        .b   (m_carry),
        .c   (~r_old),
        .cin (1'b1),
        .sum (y_out)
    );

    // next register = t + x
    lwdf_csa_add3 #(.N(N)) u_add_r (
        .a   (m_sum),
        .b   (m_carry),
        .c   (x_in),
        .cin (1'b0),
        .sum (r_new)
    );

endmodule

// File: rtl/lwdf_hilbert.sv
module lwdf_hilbert
    import lwdf_pkg::*;
#(
    parameter int             IN_W  = 12,
    parameter int             GUARD = 2,
    parameter int             FRAC  = 8,
    parameter logic [FRAC-1:0] A_POS = 8'b0000_0101,
    parameter logic [FRAC-1:0] A_NEG = 8'b0001_0000,
    parameter logic [FRAC-1:0] B_POS = 8'b0010_0100,
    parameter logic [FRAC-1:0] B_NEG = 8'b0000_0000,
    localparam int            N     = IN_W + GUARD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_sample,
    output logic            out_valid,
    output logic [N-1:0]    out_re,
    output logic [N-1:0]    out_im
);

    seq_state_t state;
    seq_state_t state_nx;

    logic [N-1:0] x_hold;
    logic [N-1:0] ra1, ra2, rb1, rb2;
    logic [N-1:0] ya_hold, yb_del;
    logic [N-1:0] re_q, im_q;

    logic          sel_b;
    logic [N-1:0]  r_sel;
    logic [FRAC-1:0] pos_sel, neg_sel;
    logic [N-1:0]  y_adp, r_adp;
    logic [N-1:0]  neg_yb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_BRA;
            ST_BRA:  state_nx = ST_BRB;
            ST_BRB:  state_nx = ST_EMIT;
            ST_EMIT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // shared adaptor operand selection
    assign sel_b   = (state == ST_BRB);
    assign r_sel   = sel_b ? rb2   : ra2;
    assign pos_sel = sel_b ? B_POS : A_POS;
    assign neg_sel = sel_b ? B_NEG : A_NEG;
    assign neg_yb  = '0 - yb_del;

    lwdf_adaptor #(.N(N), .F(FRAC)) u_adp (
        .x_in     (x_hold),
        .r_old    (r_sel),
        .pos_mask (pos_sel),
        .neg_mask (neg_sel),
        .y_out    (y_adp),
        .r_new    (r_adp)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_hold  <= '0;
            ra1     <= '0;
            ra2     <= '0;
            rb1     <= '0;
            rb2     <= '0;
            ya_hold <= '0;
            yb_del  <= '0;
            re_q    <= '0;
            im_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) x_hold <= {{GUARD{in_sample[IN_W-1]}}, in_sample};
                end
                ST_BRA: begin
                    ya_hold <= y_adp;
                    ra2     <= ra1;
                    ra1     <= r_adp;
                end
                ST_BRB: begin
                    im_q   <= $signed(ya_hold) >>> 1;
                    re_q   <= $signed(neg_yb) >>> 1;
                    yb_del <= y_adp;
                    rb2    <= rb1;
                    rb1    <= r_adp;
                end
                ST_EMIT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        out_valid = (state == ST_EMIT);
        out_re    = re_q;
        out_im    = im_q;
    end

endmodule

// File: rtl/lwdf_hilbert_chk.sv
module lwdf_hilbert_chk
    import lwdf_pkg::*;
#(
    parameter int N = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [N-1:0] out_re,
    input logic [N-1:0] out_im,
    input seq_state_t   state
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2
    accept_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid) |=> (state == ST_BRA));

    // R2
    brb_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRB) |=> out_valid);

    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRA) |-> $past(state) == ST_IDLE);

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(out_valid) |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind lwdf_hilbert lwdf_hilbert_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .state     (state)
);

// File: tb/sim_lwdf_hilbert.sv
module sim_lwdf_hilbert;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 12;
    localparam int GUARD = 2;
    localparam int FRAC  = 8;
    localparam int N     = IN_W + GUARD;
    localparam logic [FRAC-1:0] A_POS = 8'b0000_0101;
    localparam logic [FRAC-1:0] A_NEG = 8'b0001_0000;
    localparam logic [FRAC-1:0] B_POS = 8'b0010_0100;
    localparam logic [FRAC-1:0] B_NEG = 8'b0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_sample = '0;
    logic            out_valid;
    logic [N-1:0]    out_re, out_im;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [N-1:0] ma1 = '0, ma2 = '0, mb1 = '0, mb2 = '0, myb = '0;
    logic [N-1:0] last_re = '0, last_im = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwdf_hilbert #(
        .IN_W(IN_W), .GUARD(GUARD), .FRAC(FRAC),
        .A_POS(A_POS), .A_NEG(A_NEG), .B_POS(B_POS), .B_NEG(B_NEG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [N-1:0] csd_ref(input logic [N-1:0] d,
                                             input logic [FRAC-1:0] p,
                                             input logic [FRAC-1:0] n);
        logic [N-1:0] acc, sh;
        acc = '0;
        for (int k = 0; k < FRAC; k++) begin
            sh = $signed(d) >>> (k + 1);
            if (p[k])      acc = acc + sh;
            else if (n[k]) acc = acc - sh;
        end
        return acc;
    endfunction

    task automatic ref_step(input logic [IN_W-1:0] x,
                            output logic [N-1:0] e_re, output logic [N-1:0] e_im);
        logic [N-1:0] xe, d, t, ya, yb, rn, nyb;
        xe = {{GUARD{x[IN_W-1]}}, x};
        d  = xe + ma2;
        t  = csd_ref(d, A_POS, A_NEG);
        ya = t - ma2;
        rn = t + xe;
        ma2 = ma1; ma1 = rn;
        d  = xe + mb2;
        t  = csd_ref(d, B_POS, B_NEG);
        yb = t - mb2;
        rn = t + xe;
        mb2 = mb1; mb1 = rn;
        e_im = $signed(ya) >>> 1;
        nyb  = '0 - myb;
        e_re = $signed(nyb) >>> 1;
        myb  = yb;
    endtask

    // one sample; noisy keeps a junk strobe up while the block is busy
    task automatic send(input logic [IN_W-1:0] x, input bit noisy, input int gap);
        logic [N-1:0] e_re, e_im;
        @(negedge clk);
        in_valid = 1'b1; in_sample = x;
        ref_step(x, e_re, e_im);
        @(negedge clk);
        in_valid = noisy; if (noisy) in_sample = IN_W'($urandom);
        chk("R2 busy A no valid", {{(N-1){1'b0}}, out_valid}, '0);
        @(negedge clk);
        if (noisy) in_sample = IN_W'($urandom);
        chk("R2 busy B no valid", {{(N-1){1'b0}}, out_valid}, '0);
        @(negedge clk);
        if (noisy) in_sample = IN_W'($urandom);
        chk("R2 valid pulse", {{(N-1){1'b0}}, out_valid}, N'(1));
        chk("R4 R6 R8 imag out (R3 if noisy)", out_im, e_im);
        chk("R5 R6 R8 real out (R3 if noisy)", out_re, e_re);
        last_re = e_re; last_im = e_im;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 valid single cycle", {{(N-1){1'b0}}, out_valid}, '0);
        chk("R7 real hold", out_re, last_re);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk("R7 imag hold idle", out_im, last_im);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {{(N-1){1'b0}}, out_valid}, '0);
        chk("R1 reset real", out_re, '0);
        chk("R1 reset imag", out_im, '0);
        rst_n = 1'b1;
        // impulse from rest: imag = (0.59375*1024)/2 = 304, real = 0
        send(12'd1024, 1'b0, 0);
        chk("R6 impulse imag constant", out_im, N'(304));
        chk("R1 first real from rest", out_re, '0);
        repeat (6) send(12'd0, 1'b0, 1);
        send(12'h7FF, 1'b1, 2);
        send(12'h800, 1'b0, 0);
        send(12'h800, 1'b1, 0);
        send(12'h7FF, 1'b0, 3);
        for (int i = 0; i < 120; i++) begin
            logic [IN_W-1:0] v;
            case ($urandom % 4)
                0: v = 12'h7FF;
                1: v = 12'h800;
                default: v = IN_W'($urandom);
            endcase
            send(v, bit'($urandom % 2), int'($urandom % 4));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule